// File: doc/BRIEF.md
# Byte-Wide Master Configuration Loader

This block fetches configuration bytes from an external byte-wide memory and turns them into a serial bit stream with its own serial clock. It drives a memory address bus and a read strobe, takes one byte per address, and shifts the bits out one per serial clock cycle. The same serial clock and data line feed the local configuration receiver and any downstream slave devices chained behind it.

The serial clock is divided down from the system clock. The memory read cadence is locked to it: every byte fetch yields exactly eight serial clock cycles. The next address is presented while the current byte is still being shifted, so the memory has a full byte time to respond. A completion input freezes the loader once the bit in progress has finished.

Top module: `cfg_byte_loader`

## Requirements
- R1: During reset the address is 0, the serial clock is low, the read strobe is high and the serial data is 0.
- R2: While running, each serial clock high phase and each low phase lasts exactly HALF_DIV system clocks (default 2, so a period of 4 clocks).
- R3: Exactly eight serial clock pulses occur between two consecutive address changes, and the address changes once per byte.
- R4: The read strobe is high for the whole serial clock period before each byte capture. The byte on the data bus is captured, and the address advances, on the clock edge where the strobe falls.
- R5: Each byte is sent most significant bit first. The serial data changes only on the edge where the serial clock falls or the read strobe falls.
- R6: The address increments by one per byte and wraps from its all-ones value to 0 (18 bits by default).
- R7: Once the done input is high at a falling serial clock edge, or has been high since the last one, the loader stops at that edge: the serial clock stays low, the read strobe stays low, and the address and serial data stay frozen until reset. The bit in progress still completes its high phase.
- R8: After reset, one serial clock period with no serial clock pulse passes while byte 0 is fetched. The first bit appears on the data line at system clock edge 2*HALF_DIV after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Configuration complete; stops the loader |
| mem_data_i | input | DATA_W (8) | Byte read from memory |
| mem_addr_o | output | ADDR_W (18) | Memory address |
| rclk_o | output | 1 | Memory read strobe; the byte is captured as it falls |
| cclk_o | output | 1 | Generated serial clock |
| dout_o | output | 1 | Serial configuration data |

## Verification
The assertions assume that the memory data is valid by the time the read strobe falls, and that done, once raised, stays high until reset. The bench meets both conditions. It drives the data bus as a pure function of the address the block presents. It changes done only on falling system clock edges and never releases it before a reset. A reference model tracks clocks, events and a bit queue, and is compared with every output on each cycle. A second instance uses a 3-bit address and an undivided clock to reach the wrap within the run.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} cclk_phase_e;

   function automatic int cnt_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cfg_cclk_div.sv
module cfg_cclk_div
   import cfg_loader_pkg::*;
#(
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   output cclk_phase_e phase_o,
   output logic        fall_o
);
   logic tick;

   generate
      if (HALF_DIV < 1) begin : g_bad
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = cnt_bits(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    phase_o <= PH_LOW;
      else if (tick) phase_o <= (phase_o == PH_LOW) ? PH_HIGH : PH_LOW;
   end

   assign fall_o = tick && (phase_o == PH_HIGH);
endmodule

// File: rtl/cfg_byte_seq.sv
module cfg_byte_seq
   import cfg_loader_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_i,
   input  logic              done_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rclk_o,
   output logic              load_o,
   output logic              shift_o,
   output logic              run_o,
   output logic              halt_o
);
   localparam int BW = cnt_bits(DATA_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   generate
      if (ADDR_W < 1) begin : g_bad_a
         $error("ADDR_W must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_d
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [BW-1:0]     bit_q;
   logic [ADDR_W-1:0] addr_q;
   logic              run_q, halt_q, done_seen_q;
   logic              stop, step, at_last;

   assign stop    = done_seen_q | done_i;
   assign step    = fall_i & ~halt_q;
   assign at_last = (bit_q == LAST_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q       <= LAST_BIT;
         addr_q      <= '0;
         run_q       <= 1'b0;
         halt_q      <= 1'b0;
         done_seen_q <= 1'b0;
      end else begin
         if (done_i) done_seen_q <= 1'b1;
         if (step) begin
            if (stop) begin
               halt_q <= 1'b1;
            end else if (at_last) begin
               bit_q  <= '0;
               addr_q <= addr_q + 1'b1;
               run_q  <= 1'b1;
            end else begin
               bit_q  <= bit_q + 1'b1;
            end
         end
      end
   end

   assign load_o  = step & ~stop & at_last;
   assign shift_o = step & ~stop & ~at_last;
   assign rclk_o  = at_last & ~halt_q;
   assign addr_o  = addr_q;
   assign run_o   = run_q;
   assign halt_o  = halt_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> addr_q == $past(addr_q) + ADDR_W'(1)); // R6
   AST_ADDR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> $fell(rclk_o)); // R4
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> $stable(addr_q) && !rclk_o && halt_q); // R7
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              dout_o
);
   logic [DATA_W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       sr_q <= '0;
      else if (load_i)  sr_q <= data_i;
      else if (shift_i) sr_q <= MSB_FIRST ? (sr_q << 1) : (sr_q >> 1);
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign dout_o = sr_q[DATA_W-1];
      end else begin : g_lsb
         assign dout_o = sr_q[0];
      end
   endgenerate
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
   import cfg_loader_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 8,
   parameter int HALF_DIV  = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              rclk_o,
   output logic              cclk_o,
   output logic              dout_o
);
   cclk_phase_e phase;
   logic        fall, load, shift, run, halt;

   cfg_cclk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .phase_o(phase), .fall_o(fall)
   );

   cfg_byte_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .done_i(done_i),
      .addr_o(mem_addr_o), .rclk_o(rclk_o), .load_o(load),
      .shift_o(shift), .run_o(run), .halt_o(halt)
   );

   cfg_bit_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_sh (
      .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift),
      .data_i(mem_data_i), .dout_o(dout_o)
   );

   assign cclk_o = (phase == PH_HIGH) & run & ~halt;

   AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_o) |-> $fell(cclk_o) || $fell(rclk_o)); // R5
endmodule

// File: tb/sim_cfg_byte_loader.sv
`timescale 1ns/1ps
module sim_cfg_byte_loader;
   localparam int H = 2;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic done = 1'b0;
   logic [17:0] addr;
   logic [7:0]  mdata;
   logic rclk, cclk, dout;
   logic [2:0] addr1;
   logic rclk1, cclk1, dout1;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] memf(input int a);
      return 8'(((a * 29) + 7) ^ (a >> 3) ^ 8'h80);
   endfunction

   assign mdata = memf(int'(addr));

   cfg_byte_loader u0 (
      .clk(clk), .rst_n(rst_n), .done_i(done), .mem_data_i(mdata),
      .mem_addr_o(addr), .rclk_o(rclk), .cclk_o(cclk), .dout_o(dout)
   );

   cfg_byte_loader #(.ADDR_W(3), .HALF_DIV(1)) u1 (
      .clk(clk), .rst_n(rst_n), .done_i(1'b0), .mem_data_i(8'hA5),
      .mem_addr_o(addr1), .rclk_o(rclk1), .cclk_o(cclk1), .dout_o(dout1)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model, behavioural
   int   m_t, m_addr;
   bit   m_cclk, m_rclk, m_dout, m_run, m_halt, m_done;
   bit   q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t = 0; m_addr = 0; m_cclk = 0; m_rclk = 1; m_dout = 0;
         m_run = 0; m_halt = 0; m_done = 0; q.delete();
      end else begin
         if (done) m_done = 1;
         m_t++;
         if (m_t % H == 0) begin
            if (((m_t / H) % 2) == 1) begin
               if (m_run && !m_halt) m_cclk = 1;
            end else begin
               m_cclk = 0;
               if (!m_halt) begin
                  if (m_done) m_halt = 1;
                  else begin
                     if (q.size() == 0) begin
                        logic [7:0] b;
                        b = memf(m_addr);
                        for (int i = 7; i >= 0; i--) q.push_back(b[i]);
                        m_addr = (m_addr + 1) % (1 << 18);
                        m_run = 1;
                     end
                     m_dout = q.pop_front();
                  end
               end
               m_rclk = !m_halt && (q.size() == 0);
            end
         end
      end
   end

   // per-cycle comparison and monitors
   bit   p_cclk, p_rclk_seen;
   int   hi_len, lo_len, pulses, addr_prev, addr1_prev, wraps;
   bit   addr_seen, addr1_seen, mon_len;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(cclk == m_cclk, "R2", "cclk", cclk, m_cclk);
         chk(rclk == m_rclk, "R4", "rclk", rclk, m_rclk);
         chk(dout == m_dout, "R5", "dout", dout, m_dout);
         chk(int'(addr) == m_addr, "R3", "addr", addr, m_addr);
         // R2: high/low run lengths while pulsing
         if (cclk) hi_len++;
         if (!cclk && p_cclk) begin
            chk(hi_len == H, "R2", "cclk high length", hi_len, H);
            hi_len = 0; mon_len = 1;
         end
         if (!cclk && mon_len && !done) lo_len++;
         if (cclk && !p_cclk) begin
            pulses++;
            if (mon_len) chk(lo_len == H, "R2", "cclk low length", lo_len, H);
            lo_len = 0;
         end
         // R3: eight pulses between address changes
         if (int'(addr) != addr_prev) begin
            if (addr_seen) chk(pulses == 8, "R3", "pulses per byte", pulses, 8);
            else           chk(pulses == 0, "R8", "pulses before first byte", pulses, 0);
            addr_seen = 1; pulses = 0;
         end
         addr_prev = int'(addr);
         p_cclk = cclk;
         // R6: wrap on the 3-bit instance
         if (int'(addr1) != addr1_prev) begin
            chk(int'(addr1) == (addr1_prev + 1) % 8, "R6", "u1 address step",
                addr1, (addr1_prev + 1) % 8);
            if (addr1_prev == 7) wraps++;
         end
         addr1_prev = int'(addr1);
      end else begin
         p_cclk = 0; hi_len = 0; lo_len = 0; pulses = 0; mon_len = 0;
         addr_prev = 0; addr_seen = 0; addr1_prev = 0;
      end
   end

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int a0, r0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(addr == 0, "R1", "reset addr", addr, 0);
      chk(cclk == 0, "R1", "reset cclk", cclk, 0);
      chk(rclk == 1, "R1", "reset rclk", rclk, 1);
      chk(dout == 0, "R1", "reset dout", dout, 0);
      rst_n = 1;
      // R8 first bit timing
      repeat (2 * H - 1) @(negedge clk);
      chk(addr == 0 && cclk == 0, "R8", "still fetching byte 0", addr, 0);
      @(negedge clk);
      chk(addr == 1, "R8", "byte 0 loaded", addr, 1);
      chk(dout == memf(0)[7], "R5", "first bit is MSB", dout, memf(0)[7]);
      repeat (650) @(negedge clk);
      repeat (5) @(negedge clk);
      // R7 done mid-byte
      done = 1;
      repeat (3 * H) @(negedge clk);
      a0 = int'(addr); r0 = pulses;
      repeat (60) @(negedge clk);
      chk(int'(addr) == a0, "R7", "address frozen", addr, a0);
      chk(pulses == r0, "R7", "no pulses after halt", pulses, r0);
      chk(cclk == 0 && rclk == 0, "R7", "clock and strobe low", {cclk, rclk}, 0);
      chk(wraps >= 1, "R6", "u1 wrapped", wraps, 1);
      // R7/R8 done from the start: no pulse at all
      rst_n = 0; done = 0;
      repeat (2) @(negedge clk);
      rst_n = 1; done = 1;
      repeat (40) @(negedge clk);
      chk(addr == 0, "R7", "halt before first byte addr", addr, 0);
      chk(pulses == 0, "R8", "no pulse when halted in fetch", pulses, 0);
      chk(dout == 0, "R7", "dout untouched", dout, 0);
      finish_run();
   end
endmodule